// File: doc/BRIEF.md
# Peripheral Interrupt Flag and Enable Unit

This block is the interrupt front end of a single peripheral. The peripheral core gives it one-cycle condition pulses, one for each interrupt source. Each pulse latches a sticky flag bit. Software reads the flags and clears them by writing ones to the flag register. A separate enable mask decides which flags may raise an interrupt. Software changes that mask only through two write-only views: a write-one-to-set register and a write-one-to-clear register. Either address reads back the current mask.

Every source whose flag and enable bit are both 1 requests an interrupt. These requests are ORed into one registered request line toward the system interrupt controller. The register port has one write strobe per register, so the set and clear views can be written in the same cycle. This lets the unit resolve that collision in a fixed way.

Top module: `pirq_unit`

## Requirements
- R1: After reset, every flag bit and every enable bit is 0, and `irq_o` is 0.
- R2: A 1 on `cond_i[i]` at a rising clock edge sets flag i. The flag stays 1 until software clears it. Flags are read at `rd_addr` = 0.
- R3: A write with `wr_sel[0]` = 1 clears each flag whose `wr_data` bit is 1. A flag whose data bit is 0 keeps its value.
- R4: If a condition pulse and a flag-clear write hit the same flag in the same cycle, the flag is 1 afterwards.
- R5: A write with `wr_sel[1]` = 1 sets each enable bit whose `wr_data` bit is 1. All other enable bits keep their values.
- R6: A write with `wr_sel[2]` = 1 clears each enable bit whose `wr_data` bit is 1. All other enable bits keep their values.
- R7: `rd_data` returns the enable mask when `rd_addr` is 1 or 2, and returns 0 when `rd_addr` is 3. The read path is combinational.
- R8: If the set write and the clear write name the same enable bit in the same cycle, that bit is 0 afterwards.
- R9: `irq_o` is a register. After each clock edge it equals the OR over all sources of (flag AND enable), using the values that edge stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_i | input | NSRC | One-cycle interrupt condition pulses from the peripheral core |
| wr_sel | input | 3 | Write strobes: bit0 flag clear, bit1 enable set, bit2 enable clear |
| wr_data | input | NSRC | Write data shared by all strobes |
| rd_addr | input | 2 | Read select: 0 flags, 1 and 2 enable mask, 3 zero |
| rd_data | output | NSRC | Read data |
| irq_o | output | 1 | Registered peripheral interrupt request |

## Verification
The checker tests on every cycle the properties that must always hold. A flag never rises without a pulse, and a pulse always leaves its flag set even under a clear. The enable mask never changes except through its strobes, clear beats set, and the request line always matches the stored flag and enable state. The bench's scenarios show the register view as software sees it. They cover read-back at each address, a clear that leaves unnamed bits alone, zero-data writes that change nothing, and reset in the middle of a run that returns everything to 0.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  localparam int SEL_W = 3;
  localparam int SEL_FLAG_CLR = 0;
  localparam int SEL_EN_SET   = 1;
  localparam int SEL_EN_CLR   = 2;

  typedef enum logic [1:0] {
    RA_FLAGS  = 2'd0,
    RA_EN_SET = 2'd1,
    RA_EN_CLR = 2'd2,
    RA_NONE   = 2'd3
  } rd_addr_e;

  function automatic logic [63:0] w1s(input logic [63:0] cur, input logic [63:0] set);
    return cur | set;
  endfunction

  function automatic logic [63:0] w1c(input logic [63:0] cur, input logic [63:0] clr);
    return cur & ~clr;
  endfunction

  // Pulse has priority over a software clear of the same bit.
  function automatic logic [63:0] flag_next(input logic [63:0] cur,
                                            input logic [63:0] clr,
                                            input logic [63:0] pulse);
    return (cur & ~clr) | pulse;
  endfunction

  // Clear has priority over set of the same bit.
  function automatic logic [63:0] mask_next(input logic [63:0] cur,
                                            input logic [63:0] set,
                                            input logic [63:0] clr);
    return (cur | set) & ~clr;
  endfunction

endpackage

// File: rtl/pirq_flags.sv
module pirq_flags #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pulse,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] flags_d,
  output logic [NSRC-1:0] flags_q
);
  import pirq_pkg::*;

  logic [63:0] nxt;

  always_comb begin
    nxt     = flag_next(64'(flags_q), 64'(clr), 64'(pulse));
    flags_d = nxt[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/pirq_mask.sv
module pirq_mask #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] en_d,
  output logic [NSRC-1:0] en_q
);
  import pirq_pkg::*;

  logic [63:0] nxt;

  always_comb begin
    nxt  = mask_next(64'(en_q), 64'(set), 64'(clr));
    en_d = nxt[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end
endmodule

// File: rtl/pirq_reduce.sv
module pirq_reduce #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] flags_d,
  input  logic [NSRC-1:0] en_d,
  output logic [NSRC-1:0] req_vec,
  output logic            irq_q
);
  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_req
      assign req_vec[i] = flags_d[i] & en_d[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |req_vec;
  end
endmodule

// File: rtl/pirq_unit.sv
module pirq_unit #(
  parameter int NSRC = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            cond_i,
  input  logic [pirq_pkg::SEL_W-1:0] wr_sel,
  input  logic [NSRC-1:0]            wr_data,
  input  logic [1:0]                 rd_addr,
  output logic [NSRC-1:0]            rd_data,
  output logic                       irq_o
);
  import pirq_pkg::*;

  // Named internal events for the checker.
  logic [NSRC-1:0] flag_clr_w;
  logic [NSRC-1:0] en_set_w;
  logic [NSRC-1:0] en_clr_w;
  logic [NSRC-1:0] flags_d, flags_q;
  logic [NSRC-1:0] en_d, en_q;
  logic [NSRC-1:0] req_vec;

  assign flag_clr_w = wr_sel[SEL_FLAG_CLR] ? wr_data : '0;
  assign en_set_w   = wr_sel[SEL_EN_SET]   ? wr_data : '0;
  assign en_clr_w   = wr_sel[SEL_EN_CLR]   ? wr_data : '0;

  pirq_flags #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .pulse(cond_i), .clr(flag_clr_w),
    .flags_d(flags_d), .flags_q(flags_q)
  );

  pirq_mask #(.NSRC(NSRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .set(en_set_w), .clr(en_clr_w),
    .en_d(en_d), .en_q(en_q)
  );

  pirq_reduce #(.NSRC(NSRC)) u_reduce (
    .clk(clk), .rst_n(rst_n), .flags_d(flags_d), .en_d(en_d),
    .req_vec(req_vec), .irq_q(irq_o)
  );

  always_comb begin
    unique case (rd_addr_e'(rd_addr))
      RA_FLAGS:  rd_data = flags_q;
      RA_EN_SET: rd_data = en_q;
      RA_EN_CLR: rd_data = en_q;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pirq_unit_chk.sv
module pirq_unit_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] cond_i,
  input logic [NSRC-1:0] flag_clr_w,
  input logic [NSRC-1:0] en_set_w,
  input logic [NSRC-1:0] en_clr_w,
  input logic [NSRC-1:0] flags_q,
  input logic [NSRC-1:0] en_q,
  input logic            irq_o
);
  // R2: a flag rises only after a condition pulse
  a_r2_no_spurious_flag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(cond_i)) == '0));

  // R2/R4: a pulse always leaves its flag set, even under a clear
  a_r4_pulse_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i != '0) |=> ((flags_q & $past(cond_i)) == $past(cond_i)));

  // R3: a flag falls only where a clear bit was written
  a_r3_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flags_q) & ~flags_q & ~$past(flag_clr_w)) == '0));

  // R5: a set write without a clear of the same bit enables it
  a_r5_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_set_w & ~en_clr_w) != '0) |=>
      ((en_q & $past(en_set_w & ~en_clr_w)) == $past(en_set_w & ~en_clr_w)));

  // R6/R8: a clear write always leaves its bits disabled
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr_w != '0) |=> ((en_q & $past(en_clr_w)) == '0));

  // R5/R6: mask is stable when no enable strobe carries ones
  a_r6_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_set_w | en_clr_w) == '0) |=> $stable(en_q));

  // R9: request line matches stored flag and enable state
  a_r9_irq_matches: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == (|(flags_q & en_q))));
endmodule

bind pirq_unit pirq_unit_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .flag_clr_w(flag_clr_w),
  .en_set_w(en_set_w), .en_clr_w(en_clr_w), .flags_q(flags_q),
  .en_q(en_q), .irq_o(irq_o)
);

// File: tb/pirq_unit_tb.sv
module pirq_unit_tb;
  localparam int NSRC = 8;
  localparam int NV   = 11;

  typedef struct packed {
    logic [2:0]      sel;
    logic [NSRC-1:0] wdata;
    logic [NSRC-1:0] cond;
    logic [1:0]      raddr;
    logic [NSRC-1:0] exp_rd;
    logic            exp_irq;
    logic [3:0]      req;
  } vec_t;

  // sel bit0 flag clear, bit1 enable set, bit2 enable clear
  localparam vec_t VEC [NV] = '{
    '{3'b000, 8'h00, 8'h05, 2'd0, 8'h05, 1'b0, 4'd2},  // R2 pulses latch
    '{3'b010, 8'h01, 8'h00, 2'd1, 8'h01, 1'b1, 4'd5},  // R5 enable src0
    '{3'b001, 8'h04, 8'h00, 2'd0, 8'h01, 1'b1, 4'd3},  // R3 clear bit2 only
    '{3'b001, 8'h01, 8'h01, 2'd0, 8'h01, 1'b1, 4'd4},  // R4 pulse beats clear
    '{3'b001, 8'h01, 8'h00, 2'd0, 8'h00, 1'b0, 4'd3},  // R3 clear bit0
    '{3'b110, 8'h0F, 8'h00, 2'd2, 8'h00, 1'b0, 4'd8},  // R8 clear beats set
    '{3'b010, 8'hF0, 8'h00, 2'd1, 8'hF0, 1'b0, 4'd5},  // R5
    '{3'b000, 8'h00, 8'h80, 2'd3, 8'h00, 1'b1, 4'd7},  // R7 addr3 zero, R9
    '{3'b100, 8'h70, 8'h00, 2'd2, 8'h80, 1'b1, 4'd6},  // R6 partial clear
    '{3'b100, 8'h80, 8'h00, 2'd0, 8'h80, 1'b0, 4'd9},  // R6/R9 irq drops
    '{3'b001, 8'h00, 8'h00, 2'd0, 8'h80, 1'b0, 4'd3}   // R3 zero write no effect
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] cond_i = '0;
  logic [2:0]      wr_sel = '0;
  logic [NSRC-1:0] wr_data = '0;
  logic [1:0]      rd_addr = '0;
  logic [NSRC-1:0] rd_data;
  logic            irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pirq_unit #(.NSRC(NSRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [NSRC-1:0] got_rd,
                       input logic [NSRC-1:0] exp_rd, input logic got_irq,
                       input logic exp_irq);
    n_run++;
    if (got_rd !== exp_rd || got_irq !== exp_irq) begin
      n_fail++;
      $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
               tag, got_rd, got_irq, exp_rd, exp_irq);
    end
  endtask

  task automatic read_all(input string tag, input logic [NSRC-1:0] ef,
                          input logic [NSRC-1:0] em, input logic ei);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #1;
      check(tag, rd_data, (a == 0) ? ef : (a == 3) ? '0 : em, irq_o, ei);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    read_all("R1 reset state", '0, '0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      cond_i  = VEC[k].cond;
      wr_sel  = VEC[k].sel;
      wr_data = VEC[k].wdata;
      rd_addr = VEC[k].raddr;
      @(negedge clk);
      cond_i = '0; wr_sel = '0; wr_data = '0;
      check($sformatf("R%0d vector %0d", VEC[k].req, k),
            rd_data, VEC[k].exp_rd, irq_o, VEC[k].exp_irq);
    end
    // R2: flag bit7 stays set with no activity
    repeat (3) @(negedge clk);
    read_all("R2 R7 hold and readback", 8'h80, 8'h00, 1'b0);

    // R9: enabling a pending flag raises irq after that edge
    wr_sel = 3'b010; wr_data = 8'h80;
    @(negedge clk);
    wr_sel = '0; wr_data = '0;
    read_all("R9 enable pending flag", 8'h80, 8'h80, 1'b1);

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    #1;
    read_all("R1 mid-run reset", '0, '0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_all("R1 after release", '0, '0, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule